// File: doc/BRIEF.md
# One-Bit Line Time Base Corrector

This block takes a one-bit video stream, made by slicing an unstable picture source against a threshold, and re-times it onto the line timing of a stable reference. Each source line is captured into one of two 256-point line stores. Capture is clocked by the source's own sample clock and restarts at every source horizontal sync. The other store is played out on a read clock locked to the reference at 260 clocks per line, starting a fixed number of clocks after the reference horizontal drive. Because the stores alternate, any source line may start anywhere within one reference line and still come out aligned to the reference.

The only signal that crosses between the two clock domains is a single flag naming the store that was finished last. It passes through a flop chain of configurable length. The read side also watches that flag to detect that the source has gone away. If no source sync has arrived for a set number of reference lines, playback is blanked until one does.

Top module: `bit_line_tbc`

## Requirements
- R1: Two line stores are used in ping-pong fashion. Every rising edge of `srcHSync` makes the writer switch to the other store, and the store just left becomes the completed one.
- R2: The first `wrClk` edge after the one that samples `srcHSync` rising writes `wrData` to address 0 of the new store. Each later `wrClk` edge writes the next address.
- R3: After 256 samples (address 255) have been written, writing stops. Further `wrData` is discarded until the next `srcHSync` rising edge.
- R4: The `rdClk` edge that first samples `refHDrive` high is edge E. Stored sample a (0..255) is presented on `rdSample` after edge E + RD_OFFSET + 1 + a, where RD_OFFSET defaults to 2.
- R5: At edge E the reader picks the most recently completed store and keeps it for the whole line, even if the writer swaps stores during that line.
- R6: `rdValid` is high exactly during the 256 output samples of R4. While `rdValid` is low, `rdSample` is 0.
- R7: The completed-store flag reaches the read domain through a chain of SYNC_STAGES (default 2) flops. A source sync that occurs at least 100 ns before edge E is seen by that line.
- R8: If LOSS_LINES (default 2) reference edges pass with no source sync reaching the read side, `rdValid` and `rdSample` stay 0. This holds until a source sync is seen.
- R9: While `rst` is high and after it is released, `rdValid` and `rdSample` are 0. The read side treats the source as absent until its first sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Source sample clock |
| wrData | input | 1 | Sliced one-bit source sample |
| srcHSync | input | 1 | Source horizontal sync, active high |
| rdClk | input | 1 | Reference-locked read clock, 260 per line |
| refHDrive | input | 1 | Reference horizontal drive, active high |
| rst | input | 1 | Synchronous reset, active high, held over both clocks |
| rdSample | output | 1 | Re-timed one-bit sample |
| rdValid | output | 1 | High while `rdSample` carries a stored sample |

## Verification
The bench builds the block with its defaults: 256 samples per line, read offset 2, two-flop crossing and a loss limit of two lines. The read clock runs at 260 clocks per reference line, and the source clock runs at the same rate but a fraction of a cycle out of phase. The full 256-point line is therefore filled and drained. This reaches the address-255 stop, with discarded trailing data written to catch wrap-around. The bench drives source lines locked to the reference, lines jittered by up to three clocks, and a source dropout long enough to cross the two-line loss limit and then recover. Lines whose source sync falls too close to a reference edge to name one store are not scored.

// File: rtl/tbc_pkg.sv
`timescale 1ns/1ps
package tbc_pkg;

  // Write-side strobes from control to datapath.
  typedef struct packed {
    logic wrEn;    // store wrData this wrClk edge
    logic wrBank;  // store being filled
  } wrStb_t;

  // Read-side strobes from control to datapath.
  typedef struct packed {
    logic rdEn;    // read address lies inside the active window
    logic rdBank;  // store being played out this line
    logic blank;   // source considered absent
  } rdStb_t;

endpackage

// File: rtl/tbc_sync.sv
`timescale 1ns/1ps
// Flop chain carrying one level signal into the destination clock domain.
module tbc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic dstClk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge dstClk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge dstClk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/tbc_ctrl.sv
`timescale 1ns/1ps
// Address generation, store selection, clock crossing and loss detection.
module tbc_ctrl
  import tbc_pkg::*;
#(
  parameter int SAMPLES     = 256,
  parameter int RD_OFFSET   = 2,
  parameter int LOSS_LINES  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(SAMPLES),
  localparam int CW = AW + 1,
  localparam int PW = $clog2(RD_OFFSET + SAMPLES + 1),
  localparam int MW = $clog2(LOSS_LINES + 1)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rst,
  input  logic          srcHSync,
  input  logic          refHDrive,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output wrStb_t        wrStb,
  output rdStb_t        rdStb
);

  localparam logic [CW-1:0] WR_FULL  = CW'(SAMPLES);
  localparam logic [PW-1:0] RD_START = PW'(RD_OFFSET);
  localparam logic [PW-1:0] RD_END   = PW'(RD_OFFSET + SAMPLES);
  localparam logic [MW-1:0] MISS_MAX = MW'(LOSS_LINES);

  // ---------------- write clock domain ----------------
  logic          srcPrev;
  logic          srcRise;
  logic [CW-1:0] wrCnt;
  logic          fillBank;
  logic          doneBank;

  assign srcRise = srcHSync & ~srcPrev;

  always_ff @(posedge wrClk) begin
    if (rst) begin
      srcPrev  <= 1'b0;
      wrCnt    <= WR_FULL;   // nothing written until the first sync
      fillBank <= 1'b0;
      doneBank <= 1'b1;
    end else begin
      srcPrev <= srcHSync;
      if (srcRise) begin
        wrCnt    <= '0;
        fillBank <= ~fillBank;
        doneBank <= fillBank;
      end else if (wrCnt < WR_FULL) begin
        wrCnt <= wrCnt + 1'b1;
      end
    end
  end

  assign wrAddr       = wrCnt[AW-1:0];
  assign wrStb.wrEn   = !srcRise && (wrCnt < WR_FULL);
  assign wrStb.wrBank = fillBank;

  // ---------------- crossing ----------------
  logic doneSync;

  tbc_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_doneSync (
    .dstClk(rdClk),
    .rst   (rst),
    .din   (doneBank),
    .dout  (doneSync)
  );

  // ---------------- read clock domain ----------------
  logic          refPrev;
  logic          refRise;
  logic          doneSeen;
  logic          srcSeen;
  logic [PW-1:0] rdPos;
  logic          playBank;
  logic [MW-1:0] missCnt;

  assign refRise = refHDrive & ~refPrev;
  assign srcSeen = doneSync ^ doneSeen;   // flag toggles once per source sync

  always_ff @(posedge rdClk) begin
    if (rst) begin
      refPrev  <= 1'b0;
      doneSeen <= 1'b1;
      rdPos    <= RD_END;
      playBank <= 1'b0;
      missCnt  <= MISS_MAX;
    end else begin
      refPrev  <= refHDrive;
      doneSeen <= doneSync;
      if (refRise) begin
        rdPos    <= '0;
        playBank <= doneSync;
      end else if (rdPos < RD_END) begin
        rdPos <= rdPos + 1'b1;
      end
      if (srcSeen)
        missCnt <= '0;
      else if (refRise && (missCnt < MISS_MAX))
        missCnt <= missCnt + 1'b1;
    end
  end

  assign rdAddr       = AW'(rdPos - RD_START);
  assign rdStb.rdEn   = (rdPos >= RD_START) && (rdPos < RD_END);
  assign rdStb.rdBank = playBank;
  assign rdStb.blank  = (missCnt >= MISS_MAX);

endmodule

// File: rtl/tbc_datapath.sv
`timescale 1ns/1ps
// Two one-bit line stores and the registered output stage.
module tbc_datapath
  import tbc_pkg::*;
#(
  parameter int SAMPLES = 256,
  localparam int AW     = $clog2(SAMPLES),
  localparam int BANKS  = 2
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rst,
  input  logic          wrData,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  wrStb_t        wrStb,
  input  rdStb_t        rdStb,
  output logic          rdSample,
  output logic          rdValid
);

  logic [BANKS-1:0] bankBit;

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [SAMPLES-1:0] cells;

      always_ff @(posedge wrClk) begin
        if (wrStb.wrEn && (wrStb.wrBank == 1'(b)))
          cells[wrAddr] <= wrData;
      end

      assign bankBit[b] = cells[rdAddr];
    end
  endgenerate

  logic showNow;
  assign showNow = rdStb.rdEn && !rdStb.blank;

  always_ff @(posedge rdClk) begin
    if (rst) begin
      rdSample <= 1'b0;
      rdValid  <= 1'b0;
    end else begin
      rdValid  <= showNow;
      rdSample <= showNow ? bankBit[rdStb.rdBank] : 1'b0;
    end
  end

endmodule

// File: rtl/bit_line_tbc.sv
`timescale 1ns/1ps
// One-bit line time base corrector: thin top joining control and datapath.
module bit_line_tbc
  import tbc_pkg::*;
#(
  parameter int SAMPLES     = 256,
  parameter int RD_OFFSET   = 2,
  parameter int LOSS_LINES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic wrClk,
  input  logic wrData,
  input  logic srcHSync,
  input  logic rdClk,
  input  logic refHDrive,
  input  logic rst,
  output logic rdSample,
  output logic rdValid
);

  localparam int AW = $clog2(SAMPLES);

  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  wrStb_t        wrStb;
  rdStb_t        rdStb;

  tbc_ctrl #(
    .SAMPLES    (SAMPLES),
    .RD_OFFSET  (RD_OFFSET),
    .LOSS_LINES (LOSS_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rst      (rst),
    .srcHSync (srcHSync),
    .refHDrive(refHDrive),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .wrStb    (wrStb),
    .rdStb    (rdStb)
  );

  tbc_datapath #(
    .SAMPLES(SAMPLES)
  ) u_dp (
    .wrClk   (wrClk),
    .rdClk   (rdClk),
    .rst     (rst),
    .wrData  (wrData),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wrStb   (wrStb),
    .rdStb   (rdStb),
    .rdSample(rdSample),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/tbc_checker.sv
`timescale 1ns/1ps
module tbc_checker
  import tbc_pkg::*;
#(
  parameter int SAMPLES = 256,
  localparam int AW     = $clog2(SAMPLES)
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rst,
  input logic          srcHSync,
  input logic          refHDrive,
  input logic [AW-1:0] wrAddr,
  input wrStb_t        wrStb,
  input rdStb_t        rdStb,
  input logic          rdSample,
  input logic          rdValid
);

  logic srcPrevC;
  logic refPrevC;
  logic refRiseQ;
  logic srcRiseC;
  logic refRiseC;

  assign srcRiseC = srcHSync && !srcPrevC;
  assign refRiseC = refHDrive && !refPrevC;

  always_ff @(posedge wrClk) begin
    if (rst) srcPrevC <= 1'b0;
    else     srcPrevC <= srcHSync;
  end

  always_ff @(posedge rdClk) begin
    if (rst) begin
      refPrevC <= 1'b0;
      refRiseQ <= 1'b0;
    end else begin
      refPrevC <= refHDrive;
      refRiseQ <= refRiseC;
    end
  end

  // R1: every source sync edge moves the writer to the other store
  p_bank_swap_r1: assert property (@(posedge wrClk) disable iff (rst)
    srcRiseC |=> (wrStb.wrBank != $past(wrStb.wrBank)));

  // R2: first write after a sync edge lands at address 0
  p_wr_restart_r2: assert property (@(posedge wrClk) disable iff (rst)
    srcRiseC |=> (wrStb.wrEn && (wrAddr == '0)));

  // R3: no write follows the one at the last address
  p_write_stop_r3: assert property (@(posedge wrClk) disable iff (rst)
    (wrStb.wrEn && (wrAddr == AW'(SAMPLES - 1))) |=> !wrStb.wrEn);

  // R5: played store is held through the active window
  p_bank_hold_r5: assert property (@(posedge rdClk) disable iff (rst)
    (rdStb.rdEn && $past(rdStb.rdEn) && !refRiseC && !refRiseQ) |-> $stable(rdStb.rdBank));

  // R6: an active, unblanked read address yields a valid output next cycle
  p_valid_window_r6: assert property (@(posedge rdClk) disable iff (rst)
    (rdStb.rdEn && !rdStb.blank) |=> rdValid);

  // R6: idle output is zero
  p_sample_zero_r6: assert property (@(posedge rdClk) disable iff (rst)
    !rdValid |-> !rdSample);

  // R8: blanking suppresses the output
  p_blank_quiet_r8: assert property (@(posedge rdClk) disable iff (rst)
    rdStb.blank |=> (!rdValid && !rdSample));

  // R9: reset clears the output stage
  p_reset_quiet_r9: assert property (@(posedge rdClk)
    rst |=> (!rdValid && !rdSample));

endmodule

bind bit_line_tbc tbc_checker #(.SAMPLES(SAMPLES)) u_chk (
  .wrClk    (wrClk),
  .rdClk    (rdClk),
  .rst      (rst),
  .srcHSync (srcHSync),
  .refHDrive(refHDrive),
  .wrAddr   (wrAddr),
  .wrStb    (wrStb),
  .rdStb    (rdStb),
  .rdSample (rdSample),
  .rdValid  (rdValid)
);

// File: tb/sim_bit_line_tbc.sv
`timescale 1ns/1ps
module sim_bit_line_tbc;

  localparam int      SAMPLES = 256;
  localparam int      OFF     = 2;
  localparam int      LOSS    = 2;
  localparam int      LINE    = 260;
  localparam realtime PERIOD  = 20.0;
  localparam realtime MARGIN  = 100.0;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic wrData = 1'b0, srcHSync = 1'b0, refHDrive = 1'b0, rst = 1'b1;
  logic rdSample, rdValid;

  int  testCount = 0, failCount = 0, skipCount = 0;
  bit  srcDone = 1'b0, allDone = 1'b0;

  typedef struct { realtime t; int id; } syncItem_t;
  syncItem_t syncQ[$];

  bit_line_tbc #(
    .SAMPLES(SAMPLES), .RD_OFFSET(OFF), .LOSS_LINES(LOSS), .SYNC_STAGES(2)
  ) u0 (
    .wrClk(wrClk), .wrData(wrData), .srcHSync(srcHSync),
    .rdClk(rdClk), .refHDrive(refHDrive), .rst(rst),
    .rdSample(rdSample), .rdValid(rdValid)
  );

  initial forever #10 rdClk = ~rdClk;
  initial begin #7; forever #10 wrClk = ~wrClk; end

  function automatic logic patBit(int id, int a);
    int v;
    v = a * (id + 3) + id * 29 + (a >> 3) * 5;
    return v[2] ^ v[5];
  endfunction

  function automatic int jit(int i);
    return ((i * 3) % 7) - 3;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: one source line; pushes the id of the line that this sync completes.
  task automatic srcLine(int id, int len, int endedId);
    syncItem_t it;
    @(negedge wrClk);
    srcHSync = 1'b1;
    @(posedge wrClk);
    it.t = $realtime; it.id = endedId;
    syncQ.push_back(it);
    for (int a = 0; a < len - 1; a++) begin
      @(negedge wrClk);
      if (a == 2) srcHSync = 1'b0;
      // beyond the last address the data is inverted: must be discarded (R3)
      wrData = (a < SAMPLES) ? patBit(id, a) : ~patBit(id, a - SAMPLES);
    end
  endtask

  initial begin : srcDrv
    int id;
    int prevId;
    id = 0; prevId = -1;
    wait (!rst);
    repeat (130) @(negedge wrClk);
    for (int i = 0; i < 12; i++) begin          // locked lines
      srcLine(id, LINE, prevId); prevId = id; id++;
    end
    for (int i = 0; i < 14; i++) begin          // jittered lines
      srcLine(id, LINE + jit(i), prevId); prevId = id; id++;
    end
    repeat (3 * LINE + 100) @(negedge wrClk);   // source dropout
    for (int i = 0; i < 8; i++) begin
      srcLine(id, LINE, prevId); prevId = id; id++;
    end
    srcLine(id, LINE, prevId);
    srcDone = 1'b1;
  end

  // Reference driver and monitor
  initial begin : refMon
    realtime tE, prevE;
    bit      havePrev, amb, near, midLine, expLost;
    int      risesSince, lastId, extra, bad, badK, actV, expV, nValid;
    logic    gotV [LINE];
    logic    gotS [LINE];
    syncItem_t it;
    havePrev = 0; amb = 0; risesSince = 99; lastId = -1; extra = 0;
    prevE = 0.0;

    repeat (10) @(negedge rdClk);
    // R9: outputs quiet while reset is held
    check(!rdValid && !rdSample, "R9", "outputs during reset", {rdValid, rdSample}, 0);
    rst = 1'b0;
    repeat (5) @(negedge rdClk);
    check(!rdValid && !rdSample, "R9", "outputs after reset", {rdValid, rdSample}, 0);

    while (!srcDone || extra < 3) begin
      if (srcDone) extra++;
      @(negedge rdClk);
      refHDrive = 1'b1;
      @(posedge rdClk);
      tE = $realtime;
      for (int k = 0; k < LINE; k++) begin gotV[k] = 1'b0; gotS[k] = 1'b0; end
      for (int k = 0; k < LINE - 1; k++) begin
        @(negedge rdClk);
        if (k == 3) refHDrive = 1'b0;
        gotV[k] = rdValid;
        gotS[k] = rdSample;
      end

      // scoreboard: take every sync safely before this edge (R7 margin)
      while (syncQ.size() > 0 && syncQ[0].t < tE - MARGIN) begin
        it = syncQ.pop_front();
        amb = havePrev && (it.t > prevE - MARGIN) && (it.t < prevE + MARGIN);
        risesSince = 0;
        lastId = it.id;
      end
      risesSince++;
      near    = (syncQ.size() > 0) && (syncQ[0].t <= tE + MARGIN);
      midLine = (syncQ.size() > 0) && (syncQ[0].t <= tE + LINE * PERIOD);
      expLost = (risesSince >= LOSS);

      if (near || (amb && risesSince == LOSS - 1)) begin
        skipCount++;
      end else if (expLost) begin
        if (midLine) skipCount++;
        else begin
          bad = 0; badK = -1; actV = 0;
          for (int k = 0; k < LINE - 1; k++)
            if (gotV[k] !== 1'b0 || gotS[k] !== 1'b0) begin
              if (badK < 0) begin badK = k; actV = {gotV[k], gotS[k]}; end
              bad++;
            end
          check(bad == 0, "R8 R9", $sformatf("blanked line, first bad k=%0d", badK), actV, 0);
        end
      end else if (lastId < 0) begin
        skipCount++;
      end else begin
        // R6: valid count and closed window before the first sample
        nValid = 0;
        for (int k = 0; k < LINE - 1; k++) if (gotV[k] === 1'b1) nValid++;
        check(nValid == SAMPLES && gotV[0] === 1'b0 && gotV[OFF] === 1'b0,
              "R6", "valid window length", nValid, SAMPLES);
        // R1 R2 R3 R4 R5 R7: sample a appears at k = 1+OFF+a with the completed line's data
        bad = 0; badK = -1; actV = 0; expV = 0;
        for (int a = 0; a < SAMPLES; a++) begin
          if (gotV[1 + OFF + a] !== 1'b1 || gotS[1 + OFF + a] !== patBit(lastId, a)) begin
            if (badK < 0) begin
              badK = a; actV = {gotV[1 + OFF + a], gotS[1 + OFF + a]};
              expV = {1'b1, patBit(lastId, a)};
            end
            bad++;
          end
        end
        check(bad == 0, "R1 R2 R3 R4 R5 R7",
              $sformatf("line %0d data, first bad addr=%0d", lastId, badK), actV, expV);
      end
      prevE = tE;
      havePrev = 1'b1;
    end

    allDone = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin : watchdog
    #(60000 * PERIOD);
    if (!allDone) begin
      failCount++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule